// File: doc/BRIEF.md
# PCM Highway Frame Sync Format Classifier

This block watches a serial PCM highway and works out which timing format is in use, without any configuration register. It looks at the frame sync, the transmit bit clock and the receive bit clock, and samples all three on a faster system clock. Each frame sync pulse is classified by how many transmit bit clock falling edges it spans. A wide pulse gives a long-sync frame and a single-edge pulse gives a short-sync frame. The result sets the interpretation of the next frame and applies to both the transmit port and the receive port.

A third format, the 2B+D channel link, is recognised from the receive bit clock instead. When that clock pin is held at a steady high level across consecutive frame sync rising edges, the channel link is assumed. The receive bit clock is also watched for activity. If it goes quiet for longer than a set number of system-clock cycles, the classification is thrown away and must be derived again. The block moves no data bits. Its outputs are a 2-bit format code and a flag that says the code can be trusted.

Top module: `fsync_mode_classifier`

## Requirements
- R1: While reset is high and on the cycle after it, the format code is 2'b00 and the valid flag is low. The valid flag stays low until a first classification has been made.
- R2: When a frame sync pulse spans two or more falling edges of the transmit bit clock, its end sets the format code to 2'b00 (long sync) and raises the valid flag.
- R3: When a frame sync pulse spans exactly one falling edge of the transmit bit clock, its end sets the format code to 2'b01 (short sync) and raises the valid flag.
- R4: A frame sync pulse that spans no transmit bit clock falling edge changes neither the code nor the valid flag.
- R5: The classification is redone on every frame sync pulse, so a long-sync frame that follows a short-sync frame switches the code, and the reverse also holds.
- R6: When the receive bit clock stays high with no transition across two frame sync rising edges, the code becomes 2'b10 (channel link) with the valid flag high. A single such rising edge is not enough. While the channel link holds, it takes priority over frame-width results and over receive clock inactivity.
- R7: When the receive bit clock transitions again, the channel link is dropped and the valid flag goes low. It rises again at the end of the next frame sync pulse that is classified long or short.
- R8: When the receive bit clock shows no transition for STALL_CYCLES system-clock cycles outside the channel link, the valid flag goes low and frame-width results are ignored. After the clock transitions again, the next classified frame restores the valid flag.
- R9: The code 2'b11 is never reported while the valid flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clocks |
| rst | input | 1 | Synchronous active-high reset |
| fsync_i | input | 1 | Frame sync from the highway, asynchronous |
| tx_bclk_i | input | 1 | Transmit bit clock, asynchronous |
| rx_bclk_i | input | 1 | Receive bit clock, asynchronous |
| mode_o | output | 2 | Format code: 00 long, 01 short, 10 channel link |
| mode_valid_o | output | 1 | High when mode_o holds a current classification |

## Verification
The bench drives frame sync pulses that span three, two, one and zero transmit bit clock falling edges. These separate the long result from the short result at its exact edge-count boundary, and a pulse with no falling edge must leave the state unchanged. The receive bit clock is held high for one frame sync rise and then for two, which shows the single-rise case is rejected and the two-rise case accepts the channel link. It is then held low well past the inactivity limit, so the fallback can be told apart from channel-link entry. Frames sent during the inactivity are shown to be ignored until the clock runs again.

// File: rtl/pcm_fsd_pkg.sv
`timescale 1ns/1ps
package pcm_fsd_pkg;

    // Format code reported on mode_o.
    typedef enum logic [1:0] {
        FMT_LONG  = 2'b00,
        FMT_SHORT = 2'b01,
        FMT_LINK  = 2'b10,
        FMT_SPARE = 2'b11
    } pcm_fmt_e;

    // Current and previous synchronized sample of one highway pin.
    typedef struct packed {
        logic cur;
        logic prev;
    } pin_hist_t;

    // Result of measuring one frame sync pulse.
    typedef struct packed {
        logic valid;
        logic is_long;
    } frame_verdict_t;

    function automatic logic hist_rose(pin_hist_t h);
        return h.cur & ~h.prev;
    endfunction

    function automatic logic hist_fell(pin_hist_t h);
        return ~h.cur & h.prev;
    endfunction

    function automatic logic hist_toggled(pin_hist_t h);
        return h.cur ^ h.prev;
    endfunction

    function automatic pcm_fmt_e fmt_from_verdict(logic is_long);
        return is_long ? FMT_LONG : FMT_SHORT;
    endfunction

endpackage

// File: rtl/pcm_pin_tracker.sv
`timescale 1ns/1ps
module pcm_pin_tracker
    import pcm_fsd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output pin_hist_t hist_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[STAGES-1];
        end
    end

    assign hist_o.cur  = chain_q[STAGES-1];
    assign hist_o.prev = last_q;

endmodule

// File: rtl/pcm_fs_width.sv
`timescale 1ns/1ps
module pcm_fs_width
    import pcm_fsd_pkg::*;
#(
    parameter int LONG_FALLS = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  pin_hist_t      fs_i,
    input  pin_hist_t      tx_i,
    output frame_verdict_t verdict_o
);

    localparam int CW = $clog2(LONG_FALLS + 1);
    localparam logic [CW-1:0] FALLS_SAT = CW'(LONG_FALLS);

    logic [CW-1:0]  falls_q;
    frame_verdict_t verdict_q;
    logic           fs_rise, fs_fall, tx_fall;

    assign fs_rise = hist_rose(fs_i);
    assign fs_fall = hist_fell(fs_i);
    assign tx_fall = hist_fell(tx_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            falls_q   <= '0;
            verdict_q <= '0;
        end else begin
            verdict_q.valid <= 1'b0;
            if (fs_rise) begin
                falls_q <= tx_fall ? CW'(1) : '0;
            end else if (fs_i.cur && tx_fall && falls_q != FALLS_SAT) begin
                falls_q <= falls_q + CW'(1);
            end
            if (fs_fall && falls_q != '0) begin
                verdict_q.valid   <= 1'b1;
                verdict_q.is_long <= (falls_q == FALLS_SAT);
            end
        end
    end

    assign verdict_o = verdict_q;

endmodule

// File: rtl/pcm_link_watch.sv
`timescale 1ns/1ps
module pcm_link_watch
    import pcm_fsd_pkg::*;
#(
    parameter int LINK_RISES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_hist_t fs_i,
    input  pin_hist_t rx_i,
    output logic      link_o
);

    localparam int CW = $clog2(LINK_RISES + 1);
    localparam logic [CW-1:0] RISE_SAT = CW'(LINK_RISES);

    logic [CW-1:0] high_rises_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_rises_q <= '0;
        end else if (hist_toggled(rx_i)) begin
            high_rises_q <= '0;
        end else if (hist_rose(fs_i)) begin
            if (!rx_i.cur) begin
                high_rises_q <= '0;
            end else if (high_rises_q != RISE_SAT) begin
                high_rises_q <= high_rises_q + CW'(1);
            end
        end
    end

    assign link_o = (high_rises_q == RISE_SAT);

endmodule

// File: rtl/pcm_rx_stall.sv
`timescale 1ns/1ps
module pcm_rx_stall
    import pcm_fsd_pkg::*;
#(
    parameter int STALL_CYCLES = 15625
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_hist_t rx_i,
    output logic      stalled_o
);

    localparam int CW = $clog2(STALL_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STALL_CYCLES);

    logic [CW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst || hist_toggled(rx_i)) begin
            quiet_q <= '0;
        end else if (quiet_q != LIMIT) begin
            quiet_q <= quiet_q + CW'(1);
        end
    end

    assign stalled_o = (quiet_q == LIMIT);

endmodule

// File: rtl/fsync_mode_classifier.sv
`timescale 1ns/1ps
module fsync_mode_classifier
    import pcm_fsd_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int LONG_FALLS   = 2,
    parameter int LINK_RISES   = 2,
    parameter int STALL_CYCLES = 15625
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fsync_i,
    input  logic       tx_bclk_i,
    input  logic       rx_bclk_i,
    output logic [1:0] mode_o,
    output logic       mode_valid_o
);

    localparam int NUM_PINS = 3;
    localparam int PIN_FS   = 0;
    localparam int PIN_TX   = 1;
    localparam int PIN_RX   = 2;

    logic [NUM_PINS-1:0] pins_raw;
    pin_hist_t           pin_hist [NUM_PINS];
    frame_verdict_t      verdict;
    logic                link_on;
    logic                rx_stalled;
    pcm_fmt_e            mode_q;
    logic                valid_q;

    assign pins_raw[PIN_FS] = fsync_i;
    assign pins_raw[PIN_TX] = tx_bclk_i;
    assign pins_raw[PIN_RX] = rx_bclk_i;

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            pcm_pin_tracker #(.STAGES(SYNC_STAGES)) u_trk (
                .clk    (clk),
                .rst    (rst),
                .pin_i  (pins_raw[p]),
                .hist_o (pin_hist[p])
            );
        end
    endgenerate

    pcm_fs_width #(.LONG_FALLS(LONG_FALLS)) u_width (
        .clk       (clk),
        .rst       (rst),
        .fs_i      (pin_hist[PIN_FS]),
        .tx_i      (pin_hist[PIN_TX]),
        .verdict_o (verdict)
    );

    pcm_link_watch #(.LINK_RISES(LINK_RISES)) u_link (
        .clk    (clk),
        .rst    (rst),
        .fs_i   (pin_hist[PIN_FS]),
        .rx_i   (pin_hist[PIN_RX]),
        .link_o (link_on)
    );

    pcm_rx_stall #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
        .clk       (clk),
        .rst       (rst),
        .rx_i      (pin_hist[PIN_RX]),
        .stalled_o (rx_stalled)
    );

    // Priority: channel link, then a fresh frame verdict, then invalidation.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= FMT_LONG;
            valid_q <= 1'b0;
        end else if (link_on) begin
            mode_q  <= FMT_LINK;
            valid_q <= 1'b1;
        end else if (verdict.valid && !rx_stalled) begin
            mode_q  <= fmt_from_verdict(verdict.is_long);
            valid_q <= 1'b1;
        end else if (mode_q == FMT_LINK || rx_stalled) begin
            valid_q <= 1'b0;
        end
    end

    assign mode_o       = mode_q;
    assign mode_valid_o = valid_q;

endmodule

// File: rtl/fsync_mode_checker.sv
`timescale 1ns/1ps
module fsync_mode_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       mode_valid,
    input logic       link,
    input logic       stalled,
    input logic       verdict_valid,
    input logic       verdict_long
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (mode == 2'b00 && !mode_valid)); // R1

    AST_LONG_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && verdict_long && !link && !stalled)
        |=> (mode == 2'b00 && mode_valid)); // R2

    AST_SHORT_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && !verdict_long && !link && !stalled)
        |=> (mode == 2'b01 && mode_valid)); // R3

    AST_HOLD_NO_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (!verdict_valid && !link && !stalled && mode != 2'b10)
        |=> ($stable(mode) && $stable(mode_valid))); // R4

    AST_LINK_WINS: assert property (@(posedge clk) disable iff (rst)
        link |=> (mode == 2'b10 && mode_valid)); // R6

    AST_LINK_EXIT: assert property (@(posedge clk) disable iff (rst)
        ($fell(link) && !(verdict_valid && !stalled)) |=> !mode_valid); // R7

    AST_STALL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (stalled && !link) |=> !mode_valid); // R8

    AST_NO_SPARE: assert property (@(posedge clk) disable iff (rst)
        mode_valid |-> (mode != 2'b11)); // R9

endmodule

bind fsync_mode_classifier fsync_mode_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode          (mode_o),
    .mode_valid    (mode_valid_o),
    .link          (link_on),
    .stalled       (rx_stalled),
    .verdict_valid (verdict.valid),
    .verdict_long  (verdict.is_long)
);

// File: tb/fsync_mode_classifier_tb.sv
`timescale 1ns/1ps
module fsync_mode_classifier_tb;

    localparam int STALL = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic       bclk_tx;
    logic       bclk_rx;
    logic       rx_run = 1'b1;
    logic [1:0] mode;
    logic       mode_valid;
    int         n_checks = 0;
    int         n_fail = 0;
    int         spare_seen = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    fsync_mode_classifier #(.STALL_CYCLES(STALL)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .fsync_i      (fsync),
        .tx_bclk_i    (bclk_tx),
        .rx_bclk_i    (bclk_rx),
        .mode_o       (mode),
        .mode_valid_o (mode_valid)
    );

    // Bit clocks: period of 8 system cycles.
    initial begin
        bclk_tx = 1'b0;
        bclk_rx = 1'b0;
        forever begin
            repeat (4) @(negedge clk);
            bclk_tx = ~bclk_tx;
            if (rx_run) bclk_rx = ~bclk_rx;
        end
    end

    always @(negedge clk) begin
        if (!rst && mode_valid && mode == 2'b11) spare_seen++;
    end

    task automatic check(string req, logic [1:0] exp_mode, logic exp_valid, bit cmp_mode);
        n_checks++;
        if (mode_valid !== exp_valid || (cmp_mode && mode !== exp_mode)) begin
            n_fail++;
            $display("FAIL %s: mode=%b valid=%b, expected mode=%b valid=%b",
                     req, mode, mode_valid, exp_mode, exp_valid);
        end
    endtask

    task automatic send_frame(int falls);
        @(posedge bclk_tx);
        @(negedge clk) fsync = 1'b1;
        if (falls == 0) begin
            @(negedge clk) fsync = 1'b0;
        end else begin
            repeat (falls) @(negedge bclk_tx);
            @(posedge bclk_tx);
            @(negedge clk) fsync = 1'b0;
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic hold_rx(logic lvl);
        rx_run = 1'b0;
        @(negedge clk) bclk_rx = ~lvl;
        @(negedge clk) bclk_rx = lvl;
    endtask

    task automatic t_reset();
        check("R1 reset state", 2'b00, 1'b0, 1'b1);
        send_frame(0);
        check("R1/R4 no edge pulse before first classification", 2'b00, 1'b0, 1'b1);
    endtask

    task automatic t_long_short();
        send_frame(3);
        check("R2 three falls gives long", 2'b00, 1'b1, 1'b1);
        send_frame(1);
        check("R3/R5 one fall gives short", 2'b01, 1'b1, 1'b1);
        send_frame(2);
        check("R2/R5 two falls boundary gives long", 2'b00, 1'b1, 1'b1);
        send_frame(1);
        check("R3 short again", 2'b01, 1'b1, 1'b1);
        send_frame(0);
        check("R4 zero-fall pulse keeps short", 2'b01, 1'b1, 1'b1);
    endtask

    task automatic t_link();
        hold_rx(1'b1);
        send_frame(3);
        check("R6 single high rise is not link", 2'b00, 1'b1, 1'b1);
        send_frame(3);
        check("R6 two high rises give link", 2'b10, 1'b1, 1'b1);
        repeat (STALL + 100) @(negedge clk);
        send_frame(1);
        check("R6 link outranks stall and frame width", 2'b10, 1'b1, 1'b1);
        rx_run = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 rx transitions drop link", 2'b10, 1'b0, 1'b0);
        send_frame(1);
        check("R7 next short frame restores valid", 2'b01, 1'b1, 1'b1);
    endtask

    task automatic t_stall();
        hold_rx(1'b0);
        repeat (STALL + 50) @(negedge clk);
        check("R8 quiet rx clock clears valid", 2'b01, 1'b0, 1'b0);
        send_frame(3);
        check("R8 frame ignored while stalled", 2'b01, 1'b0, 1'b0);
        rx_run = 1'b1;
        repeat (10) @(negedge clk);
        send_frame(3);
        check("R8 classification resumes", 2'b00, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_long_short();
        t_link();
        t_stall();
        n_checks++;
        if (spare_seen != 0) begin
            n_fail++;
            $display("FAIL R9: spare code seen %0d times while valid, expected 0", spare_seen);
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule